// File: doc/BRIEF.md
# Dual-Output Masked Interrupt Controller

This block gathers a word of level-sensitive interrupt sources and drives two processor interrupt lines from it: a normal interrupt line and a fast interrupt line. Each line has its own enable mask over the same raw pending word. A line is raised whenever at least one pending source is also enabled for that line. The two masks are never written directly. Software sets enable bits through one register and clears them through another, so no read-modify-write sequence is needed.

Source 0 also serves as a software interrupt. A pending flip-flop is ORed into raw bit 0 and is set or cleared through two dedicated registers. A simple word-addressed register bus reads the masked status, the raw status and the enable masks for each line. Accesses to unused offsets read zero, change nothing, and produce a one-cycle error pulse.

Top module: `dual_mask_intc`

## Requirements
- R1: Raw status bit i is high exactly while source input i is high. Bit 0 is also high while the software pending flag is set. The raw word reads at word offset 1 and again at offset 9.
- R2: `irq_out` is a register. After each clock edge it is 1 if the raw word ANDed with the IRQ enable mask, as both stand after that edge, is nonzero. A source change or an enable write presented before an edge shows on `irq_out` from that edge on, and not before it.
- R3: `fiq_out` follows the same rule as `irq_out`, using the FIQ enable mask.
- R4: Writing offset 2 ORs `wdata` into the IRQ enable mask. Writing offset 3 clears each IRQ enable bit that is 1 in `wdata`. Reading offset 2 returns the IRQ mask.
- R5: Writing offset 10 ORs `wdata` into the FIQ enable mask. Writing offset 11 clears each FIQ enable bit that is 1 in `wdata`. Reading offset 10 returns the FIQ mask.
- R6: Offset 0 reads raw AND IRQ mask. Offset 8 reads raw AND FIQ mask.
- R7: A write to offset 4 with `wdata[0]`=1 sets the software pending flag. A write to offset 5 with `wdata[0]`=1 clears it. With `wdata[0]`=0, neither write has any effect. Clearing the flag does not hide a high source input 0. Reading offset 4 returns raw bit 0 in bit 0 and zero in every other bit.
- R8: Offsets 3, 5 and 11 read as zero. Writes to offsets 0, 1, 8 and 9 change no state.
- R9: Offsets 6, 7, 12, 13, 14 and 15 read as zero and ignore writes. Any read or write of one of them makes `bad_access` high for exactly the clock cycle after the access edge. Listed offsets never raise it.
- R10: Reset (synchronous, active high) clears both enable masks, the software pending flag, `irq_out`, `fiq_out` and `bad_access`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | NSRC | Level-sensitive interrupt sources |
| wr_en | input | 1 | Register write strobe, one word per cycle |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word offset of the access |
| wdata | input | NSRC | Write data |
| rdata | output | NSRC | Read data for the current `addr`, combinational |
| irq_out | output | 1 | Registered normal interrupt line |
| fiq_out | output | 1 | Registered fast interrupt line |
| bad_access | output | 1 | One-cycle pulse after an access to an unused offset |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that only one offset is accessed per cycle. As a result, a set and a clear of the same mask can never coincide, and a write to a read-only offset can never overlap with a mask write.

The stimulus drives every access for a single cycle, from the falling edge, with at most one strobe raised. It changes the source levels only between accesses. This keeps every expected value a function of one register action or one input change at a time.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int unsigned OFS_W = 4;

    typedef enum logic [OFS_W-1:0] {
        OFS_IRQ_MSK_ST = 4'd0,
        OFS_RAW_A      = 4'd1,
        OFS_IRQ_ON     = 4'd2,
        OFS_IRQ_OFF    = 4'd3,
        OFS_SW_ON      = 4'd4,
        OFS_SW_OFF     = 4'd5,
        OFS_FIQ_MSK_ST = 4'd8,
        OFS_RAW_B      = 4'd9,
        OFS_FIQ_ON     = 4'd10,
        OFS_FIQ_OFF    = 4'd11
    } reg_ofs_e;

    typedef struct packed {
        logic irq_set;
        logic irq_clr;
        logic fiq_set;
        logic fiq_clr;
        logic sw_set;
        logic sw_clr;
        logic bad;
    } wr_dec_t;

    function automatic logic ofs_listed(logic [OFS_W-1:0] a);
        case (a)
            OFS_IRQ_MSK_ST, OFS_RAW_A, OFS_IRQ_ON, OFS_IRQ_OFF,
            OFS_SW_ON, OFS_SW_OFF, OFS_FIQ_MSK_ST, OFS_RAW_B,
            OFS_FIQ_ON, OFS_FIQ_OFF: ofs_listed = 1'b1;
            default:                 ofs_listed = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/intc_decode.sv
module intc_decode
    import intc_pkg::*;
(
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [OFS_W-1:0] addr,
    input  logic             wbit0,
    output wr_dec_t          dec
);
    always_comb begin
        dec         = '0;
        dec.bad     = (wr_en | rd_en) & ~ofs_listed(addr);
        if (wr_en) begin
            dec.irq_set = (addr == OFS_IRQ_ON);
            dec.irq_clr = (addr == OFS_IRQ_OFF);
            dec.fiq_set = (addr == OFS_FIQ_ON);
            dec.fiq_clr = (addr == OFS_FIQ_OFF);
            dec.sw_set  = (addr == OFS_SW_ON)  & wbit0;
            dec.sw_clr  = (addr == OFS_SW_OFF) & wbit0;
        end
    end
endmodule

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q,
    output logic [W-1:0] en_d
);
    always_comb begin
        en_d = en_q;
        if (set_we) en_d = en_d | wdata;
        if (clr_we) en_d = en_d & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end

    // R4
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((en_q & $past(wdata)) == $past(wdata)));
    // R5
    mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((en_q & $past(wdata)) == '0));
endmodule

// File: rtl/intc_soft_pend.sv
module intc_soft_pend (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic pend_q,
    output logic pend_d
);
    always_comb begin
        pend_d = pend_q;
        if (set_req)      pend_d = 1'b1;
        else if (clr_req) pend_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= pend_d;
    end

    // R7
    soft_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_req |=> pend_q);
    // R7
    soft_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !set_req) |=> !pend_q);
endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux
    import intc_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [OFS_W-1:0] addr,
    input  logic [W-1:0]     raw,
    input  logic [W-1:0]     irq_en,
    input  logic [W-1:0]     fiq_en,
    output logic [W-1:0]     rdata
);
    always_comb begin
        case (addr)
            OFS_IRQ_MSK_ST: rdata = raw & irq_en;
            OFS_RAW_A:      rdata = raw;
            OFS_IRQ_ON:     rdata = irq_en;
            OFS_SW_ON:      rdata = {{(W-1){1'b0}}, raw[0]};
            OFS_FIQ_MSK_ST: rdata = raw & fiq_en;
            OFS_RAW_B:      rdata = raw;
            OFS_FIQ_ON:     rdata = fiq_en;
            default:        rdata = '0;
        endcase
    end
endmodule

// File: rtl/dual_mask_intc.sv
module dual_mask_intc
    import intc_pkg::*;
#(
    parameter int unsigned NSRC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_lvl,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [OFS_W-1:0] addr,
    input  logic [NSRC-1:0]  wdata,
    output logic [NSRC-1:0]  rdata,
    output logic             irq_out,
    output logic             fiq_out,
    output logic             bad_access
);
    localparam int unsigned NLINE = 2;

    wr_dec_t         dec;
    logic [NSRC-1:0] raw_q, raw_d;
    logic [NSRC-1:0] en_q [NLINE];
    logic [NSRC-1:0] en_d [NLINE];
    logic [NLINE-1:0] set_v, clr_v, line_q;
    logic            sw_q, sw_d;

    intc_decode u_dec (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wbit0 (wdata[0]),
        .dec   (dec)
    );

    assign set_v = {dec.fiq_set, dec.irq_set};
    assign clr_v = {dec.fiq_clr, dec.irq_clr};

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        intc_mask_bank #(.W(NSRC)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .set_we (set_v[g]),
            .clr_we (clr_v[g]),
            .wdata  (wdata),
            .en_q   (en_q[g]),
            .en_d   (en_d[g])
        );

        always_ff @(posedge clk) begin
            if (rst) line_q[g] <= 1'b0;
            else     line_q[g] <= |(raw_d & en_d[g]);
        end
    end

    intc_soft_pend u_sw (
        .clk     (clk),
        .rst     (rst),
        .set_req (dec.sw_set),
        .clr_req (dec.sw_clr),
        .pend_q  (sw_q),
        .pend_d  (sw_d)
    );

    assign raw_q = src_lvl | {{(NSRC-1){1'b0}}, sw_q};
    assign raw_d = src_lvl | {{(NSRC-1){1'b0}}, sw_d};

    intc_read_mux #(.W(NSRC)) u_rd (
        .addr   (addr),
        .raw    (raw_q),
        .irq_en (en_q[0]),
        .fiq_en (en_q[1]),
        .rdata  (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) bad_access <= 1'b0;
        else     bad_access <= dec.bad;
    end

    assign irq_out = line_q[0];
    assign fiq_out = line_q[1];

    // R2
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_IRQ_OFF && wdata == {NSRC{1'b1}}) |=> !irq_out);
    // R3
    fiq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_FIQ_OFF && wdata == {NSRC{1'b1}}) |=> !fiq_out);
    // R8
    ro_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == OFS_RAW_A || addr == OFS_IRQ_MSK_ST))
        |=> (en_q[0] == $past(en_q[0]) && en_q[1] == $past(en_q[1])));
    // R9
    bad_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ((wr_en || rd_en) && !ofs_listed(addr)) |=> bad_access);
    // R9
    bad_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !rd_en) |=> !bad_access);
endmodule

// File: tb/dual_mask_intc_tb.sv
module dual_mask_intc_tb;
    localparam int NSRC = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_lvl = '0;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [3:0]      addr = '0;
    logic [NSRC-1:0] wdata = '0;
    logic [NSRC-1:0] rdata;
    logic            irq_out, fiq_out, bad_access;

    int n_chk = 0;
    int n_bad = 0;

    logic [NSRC-1:0] m_ie = '0, m_fe = '0;
    logic            m_sw = 1'b0;

    always #5 clk = ~clk;

    dual_mask_intc #(.NSRC(NSRC)) u_dut (
        .clk(clk), .rst(rst), .src_lvl(src_lvl), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out),
        .fiq_out(fiq_out), .bad_access(bad_access)
    );

    task automatic chk(input string tag, input logic [NSRC-1:0] got,
                       input logic [NSRC-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [NSRC-1:0] m_raw();
        return src_lvl | {{(NSRC-1){1'b0}}, m_sw};
    endfunction

    function automatic logic [NSRC-1:0] exp_rd(input logic [3:0] a);
        case (a)
            4'd0:  return m_raw() & m_ie;
            4'd1:  return m_raw();
            4'd2:  return m_ie;
            4'd4:  return {{(NSRC-1){1'b0}}, m_raw() & 32'd1} ;
            4'd8:  return m_raw() & m_fe;
            4'd9:  return m_raw();
            4'd10: return m_fe;
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0, 4'd8:       return "R6";
            4'd1, 4'd9:       return "R1";
            4'd2:             return "R4";
            4'd10:            return "R5";
            4'd4:             return "R7";
            4'd3, 4'd5, 4'd11: return "R8";
            default:          return "R9";
        endcase
    endfunction

    function automatic logic exp_bad(input logic [3:0] a);
        return (a == 4'd6) || (a == 4'd7) || (a >= 4'd12);
    endfunction

    task automatic chk_lines();
        chk("R2 irq_out", {31'b0, irq_out}, {31'b0, |(m_raw() & m_ie)});
        chk("R3 fiq_out", {31'b0, fiq_out}, {31'b0, |(m_raw() & m_fe)});
    endtask

    task automatic op(input bit w, input logic [3:0] a, input logic [NSRC-1:0] d);
        @(negedge clk);
        wr_en = w; rd_en = !w; addr = a; wdata = d;
        #1;
        if (!w) chk(tag_of(a), rdata, exp_rd(a));
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        if (w) begin
            case (a)
                4'd2:  m_ie = m_ie | d;
                4'd3:  m_ie = m_ie & ~d;
                4'd4:  if (d[0]) m_sw = 1'b1;
                4'd5:  if (d[0]) m_sw = 1'b0;
                4'd10: m_fe = m_fe | d;
                4'd11: m_fe = m_fe & ~d;
                default: ;
            endcase
        end
        chk("R9 bad_access", {31'b0, bad_access}, {31'b0, exp_bad(a)});
        chk_lines();
    endtask

    task automatic set_src(input logic [NSRC-1:0] v);
        logic o_i, o_f;
        @(negedge clk);
        o_i = irq_out; o_f = fiq_out;
        src_lvl = v;
        #1;
        chk("R2 held before edge", {31'b0, irq_out}, {31'b0, o_i});
        chk("R3 held before edge", {31'b0, fiq_out}, {31'b0, o_f});
        @(negedge clk);
        chk_lines();
    endtask

    function automatic logic [31:0] xs(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        return y ^ (y << 5);
    endfunction

    initial begin
        #1_500_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 irq_out", {31'b0, irq_out}, '0);
        chk("R10 fiq_out", {31'b0, fiq_out}, '0);
        chk("R10 bad_access", {31'b0, bad_access}, '0);
        for (int a = 0; a < 16; a++) op(1'b0, a[3:0], '0);

        // walk each source through both lines (R2, R3, R1)
        for (int i = 0; i < NSRC; i++) begin
            op(1'b1, 4'd2, 32'd1 << i);
            set_src(32'd1 << i);
            op(1'b0, 4'd1, '0);
            op(1'b1, 4'd10, 32'd1 << i);
            set_src(~(32'd1 << i));
            op(1'b1, 4'd3, 32'hFFFF_FFFF);
            op(1'b1, 4'd11, 32'hFFFF_FFFF);
            set_src('0);
        end

        // software pending flag (R7)
        op(1'b1, 4'd4, 32'hFFFF_FFFE);
        op(1'b0, 4'd4, '0);
        op(1'b1, 4'd4, 32'd1);
        op(1'b0, 4'd4, '0);
        op(1'b1, 4'd2, 32'd1);
        op(1'b1, 4'd5, 32'hFFFF_FFFE);
        op(1'b0, 4'd1, '0);
        op(1'b1, 4'd5, 32'd1);
        op(1'b0, 4'd4, '0);
        set_src(32'd1);
        op(1'b1, 4'd5, 32'd1);
        op(1'b0, 4'd4, '0);
        set_src(32'h8000_0001);
        op(1'b0, 4'd4, '0);
        set_src('0);

        // read-only and unused offsets leave state alone (R8, R9)
        op(1'b1, 4'd10, 32'h00F0_0F00);
        for (int a = 0; a < 16; a++)
            if (a == 0 || a == 1 || a == 8 || a == 9 || a == 6 || a == 7 || a >= 12) begin
                op(1'b1, a[3:0], 32'hFFFF_FFFF);
                op(1'b0, 4'd2, '0);
                op(1'b0, 4'd10, '0);
            end

        // pseudo-random sweep
        lf = 32'h1234_5678;
        for (int k = 0; k < 64; k++) begin
            lf = xs(lf); op(1'b1, 4'd2, lf);
            lf = xs(lf); op(1'b1, 4'd3, lf);
            lf = xs(lf); op(1'b1, 4'd10, lf);
            lf = xs(lf); op(1'b1, 4'd11, lf & 32'h0F0F_0F0F);
            lf = xs(lf); op(1'b1, lf[3] ? 4'd4 : 4'd5, {31'b0, lf[7]});
            lf = xs(lf); set_src(lf & xs(lf ^ 32'h5A5A_5A5A));
            for (int a = 0; a < 16; a++) op(1'b0, a[3:0], '0);
        end

        // reset mid-run clears everything (R10)
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_ie = '0; m_fe = '0; m_sw = 1'b0; src_lvl = '0;
        @(negedge clk);
        chk("R10 irq_out after reset", {31'b0, irq_out}, '0);
        op(1'b0, 4'd2, '0);
        op(1'b0, 4'd10, '0);
        op(1'b0, 4'd4, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule